// File: doc/BRIEF.md
# Shared-Bus Arbiter with Atomic Test-and-Set

This block places several requesters on one shared bus to a small word memory held inside the block. A round-robin arbiter gives the bus to one requester at a time. Each requester accepts a command (plain read, plain write, single test-and-set, or a full lock acquire) and runs it on the bus through a small front-end state machine.

A test-and-set raises a lock line for both of its bus cycles. While the owner holds that line after its read cycle, the arbiter will not re-arbitrate, so the read and the write of one requester cannot have another requester's access between them. Without this rule, two requesters could both read a free lock and both write 1, and both would believe they own it. The acquire command repeats test-and-set until it reads 0. Between failed attempts it waits for a delay that doubles each time up to a cap. In its polling variant it first spins with plain reads and only issues the locked operation once it reads the word as free. A lock is released with an ordinary write of 0.

Top module: `lkb_top`

## Requirements
- R1: After reset no grant is given, the lock line is low, every requester reports ready, and every memory word reads 0.
- R2: Command code 0 reads the addressed word and returns it. Code 1 writes the supplied data to that word, and a later read returns it.
- R3: Command code 2 (test-and-set) returns the word's previous value and leaves the word equal to 1.
- R4: Every locked read cycle is followed in the very next cycle by a locked write cycle of the same requester. No other requester is granted in between.
- R5: When two requesters start a test-and-set on a free word in the same cycle, exactly one of them gets 0 and the other gets 1.
- R6: An acquire (code 3) with the polling flag set issues no locked cycle while the word reads nonzero. Once the word reads 0, it issues exactly one locked test-and-set.
- R7: After a failed acquire attempt, the requester stays off the bus for a delay that starts at BO_INIT cycles and doubles after each failure, saturating at BO_MAX. A requester running alone with a held lock therefore shows locked reads spaced delay+3 cycles apart.
- R8: A successful acquire returns the delay to BO_INIT, so the next acquire's first retry uses the initial delay again.
- R9: When the lock line is not holding the bus, grants rotate round-robin starting after the last granted requester. Requester 0 is first after reset.
- R10: A successful acquire completes with result 0 and leaves the word at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N_REQ | Per-requester command strobe, taken when ready |
| cmd_op | input | 2*N_REQ | Per-requester op: 0 read, 1 write, 2 test-and-set, 3 acquire |
| cmd_poll | input | N_REQ | For acquire: poll with plain reads before each locked attempt |
| cmd_addr | input | AW*N_REQ | Per-requester word address |
| cmd_wdata | input | DW*N_REQ | Per-requester write data |
| cmd_ready | output | N_REQ | Requester is idle and accepts a command |
| cmd_done | output | N_REQ | One-cycle completion pulse |
| cmd_rdata | output | DW*N_REQ | Command result, valid with cmd_done |
| bus_gnt | output | N_REQ | Current one-hot grant |
| bus_valid | output | 1 | A bus access takes place this cycle |
| bus_lock | output | 1 | Lock line of the granted requester |
| bus_we | output | 1 | Current access is a write |
| bus_addr | output | AW | Address of the current access |

## Verification
The bench builds the block with four requesters, a 16-word by 8-bit memory, an initial delay of 1 and a cap of 8. A cap of 8 means the doubling saturates after three failures, so the spacing sequence 4, 5, 7, 11, 11 shows both the growth and the clamp within one short run. Four requesters are enough to watch a full round-robin rotation, followed by a partial one that starts after the last winner. Two of them can race a test-and-set while a third stays idle. The 16-word space leaves separate words for the plain, racing, polling and backoff cases.

// File: rtl/lkb_pkg.sv
package lkb_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_TAS   = 2'd2,
      OP_ACQ   = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_POLL,
      ST_TRD,
      ST_TWR,
      ST_WAIT
   } rq_st_e;
endpackage

// File: rtl/lkb_arbiter.sv
module lkb_arbiter #(
   parameter int N_REQ = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic [N_REQ-1:0] lock,
   input  logic [N_REQ-1:0] we,
   output logic [N_REQ-1:0] gnt
);
   localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

   if (N_REQ < 2) begin : g_chk_n
      $error("lkb_arbiter needs at least two requesters");
   end

   logic [N_REQ-1:0] gnt_q;
   logic [IW-1:0]    last_q;
   logic [IW-1:0]    pick;
   logic             found;
   logic             hold;

   // the owner is between the read and write halves of a locked operation
   assign hold = |(gnt_q & req & lock & ~we);

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 1; k <= N_REQ; k++) begin
         if (!found && req[(int'(last_q) + k) % N_REQ]) begin
            found = 1'b1;
            pick  = IW'((int'(last_q) + k) % N_REQ);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         last_q <= IW'(N_REQ - 1);
      end else if (!hold) begin
         if (found) begin
            gnt_q  <= {{(N_REQ-1){1'b0}}, 1'b1} << pick;
            last_q <= pick;
         end else begin
            gnt_q <= '0;
         end
      end
   end

   assign gnt = gnt_q;

   AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt & req & lock & ~we)) |=> (gnt == $past(gnt))); // R4
   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R9
endmodule

// File: rtl/lkb_memory.sv
module lkb_memory #(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_chk_aw
      $error("lkb_memory address width out of range");
   end

   logic [DW-1:0] mem_q [DEPTH];

   assign rdata = mem_q[addr];

   if (CLEAR_ON_RST) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
         end else if (acc && we) begin
            mem_q[addr] <= wdata;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (acc && we) mem_q[addr] <= wdata;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && we) |=> (mem_q[$past(addr)] == $past(wdata))); // R2
endmodule

// File: rtl/lkb_requester.sv
module lkb_requester
   import lkb_pkg::*;
#(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int BO_INIT = 1,
   parameter int BO_MAX  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic          cmd_poll,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   output logic          cmd_ready,
   output logic          cmd_done,
   output logic [DW-1:0] cmd_rdata,
   input  logic          gnt,
   input  logic [DW-1:0] bus_rdata,
   output logic          rq_req,
   output logic          rq_lock,
   output logic          rq_we,
   output logic [AW-1:0] rq_addr,
   output logic [DW-1:0] rq_wdata
);
   localparam int BO_W = $clog2(BO_MAX + 1);
   localparam logic [BO_W-1:0] D_INIT = BO_W'(BO_INIT);
   localparam logic [BO_W-1:0] D_MAX  = BO_W'(BO_MAX);
   localparam logic [DW-1:0]   SET_VAL = DW'(1);

   if (BO_INIT < 1 || BO_MAX < BO_INIT) begin : g_chk_bo
      $error("lkb_requester backoff limits invalid");
   end

   rq_st_e          st_q;
   logic            acq_q, poll_q, done_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q, old_q, rdata_q;
   logic [BO_W-1:0] delay_q, cnt_q, delay_nx;
   logic [BO_W:0]   dbl;
   logic            served;

   assign served   = gnt & rq_req;
   assign dbl      = {delay_q, 1'b0};
   assign delay_nx = (dbl > {1'b0, D_MAX}) ? D_MAX : dbl[BO_W-1:0];

   assign rq_req   = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_POLL)
                   || (st_q == ST_TRD) || (st_q == ST_TWR);
   assign rq_lock  = (st_q == ST_TRD) || (st_q == ST_TWR);
   assign rq_we    = (st_q == ST_WR) || (st_q == ST_TWR);
   assign rq_addr  = addr_q;
   assign rq_wdata = (st_q == ST_TWR) ? SET_VAL : wdata_q;

   assign cmd_ready = (st_q == ST_IDLE);
   assign cmd_done  = done_q;
   assign cmd_rdata = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         acq_q   <= 1'b0;
         poll_q  <= 1'b0;
         done_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         old_q   <= '0;
         rdata_q <= '0;
         delay_q <= D_INIT;
         cnt_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (cmd_valid) begin
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               poll_q  <= cmd_poll;
               acq_q   <= (op_e'(cmd_op) == OP_ACQ);
               unique case (op_e'(cmd_op))
                  OP_READ:  st_q <= ST_RD;
                  OP_WRITE: st_q <= ST_WR;
                  OP_TAS:   st_q <= ST_TRD;
                  OP_ACQ:   st_q <= cmd_poll ? ST_POLL : ST_TRD;
               endcase
            end
            ST_RD: if (served) begin
               rdata_q <= bus_rdata;
               done_q  <= 1'b1;
               st_q    <= ST_IDLE;
            end
            ST_WR: if (served) begin
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_POLL: if (served && bus_rdata == '0) begin
               st_q <= ST_TRD;
            end
            ST_TRD: if (served) begin
               old_q <= bus_rdata;
               st_q  <= ST_TWR;
            end
            ST_TWR: if (served) begin
               if (!acq_q) begin
                  rdata_q <= old_q;
                  done_q  <= 1'b1;
                  st_q    <= ST_IDLE;
               end else if (old_q == '0) begin
                  rdata_q <= '0;
                  done_q  <= 1'b1;
                  delay_q <= D_INIT;
                  st_q    <= ST_IDLE;
               end else begin
                  cnt_q   <= delay_q;
                  delay_q <= delay_nx;
                  st_q    <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (cnt_q <= BO_W'(1)) st_q <= poll_q ? ST_POLL : ST_TRD;
               else                   cnt_q <= cnt_q - BO_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_LOCK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_lock && !rq_we && served) |=> (rq_lock && rq_we)); // R4
   AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_q >= D_INIT) && (delay_q <= D_MAX)); // R7
   AST_WIN_RESETS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && acq_q) |-> (delay_q == D_INIT)); // R8
   AST_WAIT_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> !rq_req); // R7
endmodule

// File: rtl/lkb_top.sv
module lkb_top #(
   parameter int N_REQ   = 4,
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int BO_INIT = 1,
   parameter int BO_MAX  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_REQ-1:0]    cmd_valid,
   input  logic [2*N_REQ-1:0]  cmd_op,
   input  logic [N_REQ-1:0]    cmd_poll,
   input  logic [AW*N_REQ-1:0] cmd_addr,
   input  logic [DW*N_REQ-1:0] cmd_wdata,
   output logic [N_REQ-1:0]    cmd_ready,
   output logic [N_REQ-1:0]    cmd_done,
   output logic [DW*N_REQ-1:0] cmd_rdata,
   output logic [N_REQ-1:0]    bus_gnt,
   output logic                bus_valid,
   output logic                bus_lock,
   output logic                bus_we,
   output logic [AW-1:0]       bus_addr
);
   logic [N_REQ-1:0] rq_req, rq_lock, rq_we;
   logic [AW-1:0]    rq_addr  [N_REQ];
   logic [DW-1:0]    rq_wdata [N_REQ];
   logic [DW-1:0]    mem_rdata, b_wdata;
   logic [AW-1:0]    b_addr;

   lkb_arbiter #(.N_REQ(N_REQ)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(rq_req), .lock(rq_lock), .we(rq_we), .gnt(bus_gnt)
   );

   for (genvar i = 0; i < N_REQ; i++) begin : g_rq
      lkb_requester #(.AW(AW), .DW(DW), .BO_INIT(BO_INIT), .BO_MAX(BO_MAX)) u_rq (
         .clk(clk), .rst_n(rst_n),
         .cmd_valid(cmd_valid[i]), .cmd_op(cmd_op[2*i +: 2]), .cmd_poll(cmd_poll[i]),
         .cmd_addr(cmd_addr[AW*i +: AW]), .cmd_wdata(cmd_wdata[DW*i +: DW]),
         .cmd_ready(cmd_ready[i]), .cmd_done(cmd_done[i]), .cmd_rdata(cmd_rdata[DW*i +: DW]),
         .gnt(bus_gnt[i]), .bus_rdata(mem_rdata),
         .rq_req(rq_req[i]), .rq_lock(rq_lock[i]), .rq_we(rq_we[i]),
         .rq_addr(rq_addr[i]), .rq_wdata(rq_wdata[i])
      );
   end

   // one-hot grant: OR of the owner's fields
   always_comb begin
      b_addr   = '0;
      b_wdata  = '0;
      bus_lock = 1'b0;
      bus_we   = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         b_addr   = b_addr  | (rq_addr[i]  & {AW{bus_gnt[i]}});
         b_wdata  = b_wdata | (rq_wdata[i] & {DW{bus_gnt[i]}});
         bus_lock = bus_lock | (rq_lock[i] & bus_gnt[i]);
         bus_we   = bus_we   | (rq_we[i]   & bus_gnt[i]);
      end
   end

   assign bus_valid = |(bus_gnt & rq_req);
   assign bus_addr  = b_addr;

   lkb_memory #(.AW(AW), .DW(DW), .CLEAR_ON_RST(1'b1)) u_mem (
      .clk(clk), .rst_n(rst_n), .acc(bus_valid), .we(bus_we),
      .addr(b_addr), .wdata(b_wdata), .rdata(mem_rdata)
   );

   AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_lock && !bus_we) |=>
      (bus_valid && bus_lock && bus_we && bus_gnt == $past(bus_gnt))); // R4
   AST_TAS_WRITES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_lock && bus_we) |-> (b_wdata == DW'(1))); // R3
   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_gnt)); // R9
endmodule

// File: tb/sim_lkb_top.sv
module sim_lkb_top;
   localparam int CLK_P = 10;
   localparam int N = 4, AW = 4, DW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] cmd_valid = '0, cmd_poll = '0;
   logic [2*N-1:0] cmd_op = '0;
   logic [AW*N-1:0] cmd_addr = '0;
   logic [DW*N-1:0] cmd_wdata = '0;
   logic [N-1:0] cmd_ready, cmd_done, bus_gnt;
   logic [DW*N-1:0] cmd_rdata;
   logic bus_valid, bus_lock, bus_we;
   logic [AW-1:0] bus_addr;

   lkb_top #(.N_REQ(N), .AW(AW), .DW(DW), .BO_INIT(1), .BO_MAX(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_poll(cmd_poll),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
      .cmd_rdata(cmd_rdata), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_lock(bus_lock),
      .bus_we(bus_we), .bus_addr(bus_addr)
   );

   always #(CLK_P/2) clk = ~clk;

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;
   int lr_cnt [N];
   int rd_cnt [N];
   int ts2 [32];
   int ts_n = 0;
   bit pend = 0;
   logic [N-1:0] pend_g = '0;

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial for (int i = 0; i < N; i++) begin lr_cnt[i] = 0; rd_cnt[i] = 0; end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // bus monitor: locked read must be followed at once by the same owner's write (R4)
   always @(negedge clk) if (rst_n) begin
      int idx;
      idx = 0;
      for (int i = 0; i < N; i++) if (bus_gnt[i]) idx = i;
      if (pend) begin
         chk(bus_valid && bus_lock && bus_we && bus_gnt == pend_g, "R4 split",
             int'(bus_gnt), int'(pend_g));
         pend = 0;
      end
      if (bus_valid && bus_lock && !bus_we) begin
         pend = 1; pend_g = bus_gnt;
         lr_cnt[idx]++;
         if (idx == 2 && ts_n < 32) begin ts2[ts_n] = cyc; ts_n++; end
      end
      if (bus_valid && !bus_lock && !bus_we) rd_cnt[idx]++;
   end

   task automatic do_op(int i, logic [1:0] op, logic poll, logic [AW-1:0] a,
                        logic [DW-1:0] d, output logic [DW-1:0] r, output int c);
      cmd_valid[i] = 1'b1;
      cmd_op[2*i +: 2] = op;
      cmd_poll[i] = poll;
      cmd_addr[AW*i +: AW] = a;
      cmd_wdata[DW*i +: DW] = d;
      @(negedge clk);
      cmd_valid[i] = 1'b0;
      while (!cmd_done[i]) @(negedge clk);
      r = cmd_rdata[DW*i +: DW];
      c = cyc;
   endtask

   // {op, addr, wdata, expected}
   localparam int NV = 11;
   localparam logic [21:0] VEC [NV] = '{
      {2'd1, 4'h2, 8'h5A, 8'h00},
      {2'd0, 4'h2, 8'h00, 8'h5A},
      {2'd2, 4'h2, 8'h00, 8'h5A},
      {2'd0, 4'h2, 8'h00, 8'h01},
      {2'd2, 4'h9, 8'h00, 8'h00},
      {2'd2, 4'h9, 8'h00, 8'h01},
      {2'd1, 4'h9, 8'h00, 8'h00},
      {2'd0, 4'h9, 8'h00, 8'h00},
      {2'd1, 4'hF, 8'hC3, 8'h00},
      {2'd0, 4'hF, 8'h00, 8'hC3},
      {2'd0, 4'h0, 8'h00, 8'h00}
   };

   initial begin
      logic [DW-1:0] r, r0, r1;
      int c, c0, c1, c2, c3, base;
      repeat (3) @(negedge clk);
      chk(bus_gnt == '0 && !bus_lock, "R1 no grant", int'(bus_gnt), 0);
      chk(cmd_ready == '1 && cmd_done == '0, "R1 ready", int'(cmd_ready), 15);
      rst_n = 1'b1;
      @(negedge clk);
      do_op(3, 2'd0, 0, 4'hE, 8'h00, r, c);
      chk(r == 8'h00, "R1 mem cleared", int'(r), 0);

      // vector table: plain and test-and-set ops, R2 and R3
      for (int v = 0; v < NV; v++) begin
         do_op(3, VEC[v][21:20], 0, VEC[v][19:16], VEC[v][15:8], r, c);
         if (VEC[v][21:20] != 2'd1)
            chk(r == VEC[v][7:0], (VEC[v][21:20] == 2'd2) ? "R3 tas old" : "R2 read",
                int'(r), int'(VEC[v][7:0]));
      end

      // R5: simultaneous test-and-set on free word 5
      fork
         do_op(0, 2'd2, 0, 4'h5, 8'h00, r0, c0);
         do_op(1, 2'd2, 0, 4'h5, 8'h00, r1, c1);
      join
      chk((r0 + r1) == 1 && r0 <= 1 && r1 <= 1, "R5 one winner", int'(r0)*10 + int'(r1), 1);
      do_op(3, 2'd0, 0, 4'h5, 8'h00, r, c);
      chk(r == 8'h01, "R3 word set", int'(r), 1);

      // R6: polling acquire on held word 3
      do_op(0, 2'd1, 0, 4'h3, 8'h01, r, c);
      base = lr_cnt[1];
      c2 = rd_cnt[1];
      fork
         do_op(1, 2'd3, 1, 4'h3, 8'h00, r1, c1);
         begin
            repeat (30) @(negedge clk);
            chk(lr_cnt[1] == base, "R6 no locked while held", lr_cnt[1], base);
            chk(rd_cnt[1] - c2 > 20, "R6 polling reads", rd_cnt[1] - c2, 21);
            do_op(0, 2'd1, 0, 4'h3, 8'h00, r0, c0);
         end
      join
      chk(lr_cnt[1] == base + 1, "R6 single locked attempt", lr_cnt[1], base + 1);
      chk(r1 == 8'h00, "R10 acquire result", int'(r1), 0);
      do_op(3, 2'd0, 0, 4'h3, 8'h00, r, c);
      chk(r == 8'h01, "R10 word held", int'(r), 1);

      // R7: plain acquire on held word 7, spacing delay+3 with 1,2,4,8,8
      do_op(0, 2'd1, 0, 4'h7, 8'h01, r, c);
      base = ts_n;
      fork
         do_op(2, 2'd3, 0, 4'h7, 8'h00, r1, c1);
         begin
            while (ts_n < base + 6) @(negedge clk);
            do_op(0, 2'd1, 0, 4'h7, 8'h00, r0, c0);
         end
      join
      chk(ts2[base+1] - ts2[base]   == 4,  "R7 gap d1", ts2[base+1] - ts2[base], 4);
      chk(ts2[base+2] - ts2[base+1] == 5,  "R7 gap d2", ts2[base+2] - ts2[base+1], 5);
      chk(ts2[base+3] - ts2[base+2] == 7,  "R7 gap d4", ts2[base+3] - ts2[base+2], 7);
      chk(ts2[base+4] - ts2[base+3] == 11, "R7 gap d8", ts2[base+4] - ts2[base+3], 11);
      chk(ts2[base+5] - ts2[base+4] == 11, "R7 gap cap", ts2[base+5] - ts2[base+4], 11);
      chk(r1 == 8'h00, "R10 backoff acquire", int'(r1), 0);

      // R8: word 7 now held by requester 2; a new acquire restarts at delay 1
      base = ts_n;
      fork
         do_op(2, 2'd3, 0, 4'h7, 8'h00, r1, c1);
         begin
            while (ts_n < base + 2) @(negedge clk);
            do_op(0, 2'd1, 0, 4'h7, 8'h00, r0, c0);
         end
      join
      chk(ts2[base+1] - ts2[base] == 4, "R8 delay reset", ts2[base+1] - ts2[base], 4);

      // R9: round robin after a fresh reset
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         do_op(0, 2'd0, 0, 4'h1, 8'h00, r, c0);
         do_op(1, 2'd0, 0, 4'h1, 8'h00, r0, c1);
         do_op(2, 2'd0, 0, 4'h1, 8'h00, r1, c2);
         do_op(3, 2'd0, 0, 4'h1, 8'h00, r, c3);
      join
      chk(c1 == c0 + 1 && c2 == c1 + 1 && c3 == c2 + 1, "R9 order 0123",
          (c1 - c0) * 100 + (c2 - c1) * 10 + (c3 - c2), 111);
      fork
         do_op(0, 2'd0, 0, 4'h1, 8'h00, r, c0);
         do_op(1, 2'd0, 0, 4'h1, 8'h00, r0, c1);
         do_op(3, 2'd0, 0, 4'h1, 8'h00, r1, c3);
      join
      chk(c1 == c0 + 1 && c3 == c1 + 1, "R9 order after 3", (c1 - c0) * 10 + (c3 - c1), 11);

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule